// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns a stream of 32-bit audio samples into a synchronous serial audio signal. It derives a bit clock from the system clock and drives a frame sync pulse and one serial data line. The frame layout is programmable: how many words make up a frame, the width of the first word and of the words after it, the sync pulse length, which bit of each sample leaves first, the shift direction, an early sync option and the polarity of both clocks. Samples enter through a valid/ready stream into a 32-entry FIFO.

A level request tells an upstream mover when the FIFO has room. The request is raised while the fill level is at or below a watermark. If a word is due while the FIFO is empty, the block sends zeros for that word and sets an error flag, which can raise an interrupt. The configuration fields are written through a plain write port. They are frozen while the transmitter is enabled.

Top module: `audio_frame_tx`

## Requirements
- R1: The bit clock has a period of (div+1)*2 clock cycles and runs only while the bit clock enable is set. When that enable is clear the internal level is 0. The output is that level XOR the bit-clock invert bit. Data, sync and word fetches advance only on the internal high-to-low transition, called the drive edge.
- R2: Within a word, bit k of the word (k counting from 0) is the sample bit at index first_bit-k when msb-first is set, and first_bit+k otherwise. An index outside 0..31 sends 0.
- R3: The FIFO holds 32 words. A word is accepted when s_valid and s_ready are both high. s_ready is low exactly when 32 words are held. s_data must be stable while s_valid is high and s_ready is low.
- R4: A frame holds words_m1+1 words. Word 0 is w0_m1+1 bits long and every later word is wn_m1+1 bits long. Each word pulls one entry from the FIFO at its first bit.
- R5: The frame sync is active on bit slots 0..sync_m1 of each frame. With early set, it is active one bit clock sooner, that is, on the slot before each of those slots. The output is inverted when the sync-active-low bit is set.
- R6: Register map (word address on cfg_addr):
  - Address 0 (control, always writable): bit0 transmit enable, bit1 bit clock enable, bit2 request enable, bit3 interrupt enable, bit4 written as 1 clears the error flag.
  - Address 1: [7:0] div, [8] bit-clock invert.
  - Address 2: [4:0] words_m1, [12:8] sync_m1, [16] early, [17] sync active low, [18] msb-first.
  - Address 3: [4:0] w0_m1, [12:8] wn_m1, [20:16] first_bit.
  - Address 4: [4:0] watermark.
  - Writes to addresses 1 to 4 are ignored while transmit enable is set.
- R7: fifo_req_o is high exactly when request enable is set and the FIFO level is at or below the watermark.
- R8: When a word is due with the FIFO empty, the word is sent as zeros and the error flag is set. irq_o equals the error flag ANDed with interrupt enable. Setting the flag wins over a clear in the same cycle.
- R9: With early clear, the first drive edge after transmit enable starts slot 0 of a frame. With early set, that first drive edge is a lead-in slot: sync is active and the data is 0. While transmit enable is clear, the sync is inactive, the data is 0 and the frame position returns to its start.
- R10: After reset all registers are 0, the FIFO is empty, the bit clock and data are low, the sync is low, and the request and interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | FIFO can take a sample |
| s_data | input | 32 | Sample word |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data |
| fifo_req_o | output | 1 | Watermark request |
| err_flag_o | output | 1 | Underrun flag |
| irq_o | output | 1 | Underrun interrupt |

## Verification
The assertions assume that the configuration stays fixed while a frame is in flight. That holds by design, because of the lock. They also assume that the bit clock enable is never set while a new divider smaller than the running count takes effect. The stimulus therefore clears both enables before any reconfiguration. They further assume that s_data is held while s_valid waits on a low s_ready. The bench holds the data word for the whole stall whenever the FIFO is full.

// File: rtl/afx_pkg.sv
package afx_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 5;
  localparam int DIV_W     = 8;
  localparam int ADDR_W    = 3;
  localparam int FIFO_DEPTH = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FRM  = 3'd2;
  localparam logic [ADDR_W-1:0] A_WRD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_WM   = 3'd4;

  typedef struct packed {
    logic [DIV_W-1:0]   div;
    logic               bclk_inv;
    logic [FIELD_W-1:0] words_m1;
    logic [FIELD_W-1:0] sync_m1;
    logic               early;
    logic               fs_low;
    logic               msb_first;
    logic [FIELD_W-1:0] w0_m1;
    logic [FIELD_W-1:0] wn_m1;
    logic [FIELD_W-1:0] first_bit;
    logic [FIELD_W-1:0] wmark;
  } afx_cfg_t;
endpackage

// File: rtl/afx_cfg_regs.sv
module afx_cfg_regs
  import afx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                set_err,
  output afx_cfg_t            cfg,
  output logic                tx_en,
  output logic                bclk_en,
  output logic                req_en,
  output logic                irq_en,
  output logic                err_flag
);
  logic ctrl_wr;
  logic cfg_wr;
  assign ctrl_wr = we && (addr == A_CTRL);
  assign cfg_wr  = we && !tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      bclk_en <= 1'b0;
      req_en  <= 1'b0;
      irq_en  <= 1'b0;
    end else if (ctrl_wr) begin
      tx_en   <= wdata[0];
      bclk_en <= wdata[1];
      req_en  <= wdata[2];
      irq_en  <= wdata[3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
    end else if (set_err) begin
      err_flag <= 1'b1;
    end else if (ctrl_wr && wdata[4]) begin
      err_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      case (addr)
        A_CLK: begin
          cfg.div      <= wdata[DIV_W-1:0];
          cfg.bclk_inv <= wdata[8];
        end
        A_FRM: begin
          cfg.words_m1  <= wdata[4:0];
          cfg.sync_m1   <= wdata[12:8];
          cfg.early     <= wdata[16];
          cfg.fs_low    <= wdata[17];
          cfg.msb_first <= wdata[18];
        end
        A_WRD: begin
          cfg.w0_m1     <= wdata[4:0];
          cfg.wn_m1     <= wdata[12:8];
          cfg.first_bit <= wdata[20:16];
        end
        A_WM: cfg.wmark <= wdata[4:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/afx_bclk_gen.sv
module afx_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             lvl,
  output logic             drive_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap       = (cnt == div);
  assign drive_tick = en && wrap && lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      lvl <= ~lvl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/afx_fifo.sv
module afx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          do_push;
  logic          do_pop;

  assign full    = (count == DEPTH[AW:0]);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/afx_frame_engine.sv
module afx_frame_engine
  import afx_pkg::*;
#(
  parameter int SLOT_W = $clog2(32 * 32) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  afx_cfg_t          cfg,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_head,
  output logic              pop,
  output logic              underrun,
  output logic              fs_act,
  output logic              sdata
);
  logic                started;
  logic [SLOT_W-1:0]   slot;
  logic [FIELD_W-1:0]  widx;
  logic [FIELD_W-1:0]  bitk;
  logic [WORD_W-1:0]   shreg;

  logic                lead;
  logic                act;
  logic                word_start;
  logic [WORD_W-1:0]   word_now;
  logic [FIELD_W+1:0]  idx;
  logic                bit_out;
  logic [FIELD_W-1:0]  cur_w;
  logic                last_bit;
  logic                last_word;
  logic [SLOT_W-1:0]   slot_nx;
  logic [SLOT_W-1:0]   sync_ext;
  logic                fs_nx;

  assign lead       = cfg.early && !started;
  assign act        = run && tick && !lead;
  assign word_start = (bitk == '0);
  assign word_now   = word_start ? (fifo_empty ? '0 : fifo_head) : shreg;
  assign pop        = act && word_start && !fifo_empty;
  assign underrun   = act && word_start && fifo_empty;

  always_comb begin
    if (cfg.msb_first) idx = {2'b00, cfg.first_bit} - {2'b00, bitk};
    else               idx = {2'b00, cfg.first_bit} + {2'b00, bitk};
  end

  assign bit_out   = (idx[FIELD_W+1:FIELD_W] == 2'b00) ? word_now[idx[FIELD_W-1:0]] : 1'b0;
  assign cur_w     = (widx == '0) ? cfg.w0_m1 : cfg.wn_m1;
  assign last_bit  = (bitk == cur_w);
  assign last_word = (widx == cfg.words_m1);
  assign slot_nx   = (last_bit && last_word) ? '0 : slot + 1'b1;
  assign sync_ext  = SLOT_W'(cfg.sync_m1);
  assign fs_nx     = cfg.early ? (slot_nx <= sync_ext) : (slot <= sync_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      slot    <= '0;
      widx    <= '0;
      bitk    <= '0;
      shreg   <= '0;
      fs_act  <= 1'b0;
      sdata   <= 1'b0;
    end else if (!run) begin
      started <= 1'b0;
      slot    <= '0;
      widx    <= '0;
      bitk    <= '0;
      fs_act  <= 1'b0;
      sdata   <= 1'b0;
    end else if (tick) begin
      started <= 1'b1;
      if (lead) begin
        fs_act <= 1'b1;
        sdata  <= 1'b0;
      end else begin
        shreg  <= word_now;
        sdata  <= bit_out;
        fs_act <= fs_nx;
        slot   <= slot_nx;
        if (last_bit) begin
          bitk <= '0;
          widx <= last_word ? '0 : widx + 1'b1;
        end else begin
          bitk <= bitk + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import afx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_data,
  output logic        bclk_o,
  output logic        fsync_o,
  output logic        sdata_o,
  output logic        fifo_req_o,
  output logic        err_flag_o,
  output logic        irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  afx_cfg_t          cfg;
  logic              tx_en, bclk_en, req_en, irq_en, err_flag;
  logic              bclk_lvl, tick;
  logic              pop, underrun, fs_act, sdata;
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  fifo_count;
  logic              full, empty;

  afx_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .set_err(underrun), .cfg(cfg), .tx_en(tx_en), .bclk_en(bclk_en),
    .req_en(req_en), .irq_en(irq_en), .err_flag(err_flag)
  );

  afx_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .en(bclk_en), .div(cfg.div),
    .lvl(bclk_lvl), .drive_tick(tick)
  );

  afx_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(s_valid), .din(s_data), .pop(pop),
    .head(head), .count(fifo_count), .full(full), .empty(empty)
  );

  afx_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .run(tx_en), .tick(tick), .cfg(cfg),
    .fifo_empty(empty), .fifo_head(head), .pop(pop), .underrun(underrun),
    .fs_act(fs_act), .sdata(sdata)
  );

  assign s_ready    = !full;
  assign bclk_o     = bclk_lvl ^ cfg.bclk_inv;
  assign fsync_o    = fs_act ^ cfg.fs_low;
  assign sdata_o    = sdata;
  assign fifo_req_o = req_en && (fifo_count <= CNT_W'(cfg.wmark));
  assign err_flag_o = err_flag;
  assign irq_o      = err_flag && irq_en;
endmodule

// File: rtl/afx_checker.sv
module afx_checker
  import afx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       bclk_en,
  input logic       bclk_lvl,
  input afx_cfg_t   cfg,
  input logic [5:0] fifo_count,
  input logic       underrun,
  input logic       err_flag,
  input logic       fs_act,
  input logic       sdata
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= 6'(FIFO_DEPTH));

  p_cfg_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_en) |-> $stable(cfg));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tx_en) |-> (!fs_act && !sdata));

  p_underrun_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> err_flag);

  p_bclk_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bclk_en) |-> !bclk_lvl);
endmodule

bind audio_frame_tx afx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bclk_en(bclk_en),
  .bclk_lvl(bclk_lvl), .cfg(cfg), .fifo_count(fifo_count),
  .underrun(underrun), .err_flag(err_flag), .fs_act(fs_act), .sdata(sdata)
);

// File: tb/audio_frame_tx_tb_top.sv
`timescale 1ns/1ps
module audio_frame_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_ready, bclk_o, fsync_o, sdata_o, fifo_req_o, err_flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  audio_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .sdata_o(sdata_o),
    .fifo_req_o(fifo_req_o), .err_flag_o(err_flag_o), .irq_o(irq_o)
  );

  // behavioural reference
  logic [31:0] mq[$];
  bit m_tx, m_bce, m_req, m_ie, m_err;
  int m_div, m_fw, m_sw, m_w0, m_wn, m_fb, m_wm;
  bit m_bpol, m_early, m_fsl, m_msb;
  int m_cnt; bit m_lvl;
  bit m_started, m_fs, m_sd;
  int m_slot, m_w, m_k;
  logic [31:0] m_word;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete();
      {m_tx, m_bce, m_req, m_ie, m_err} = '0;
      m_div = 0; m_fw = 0; m_sw = 0; m_w0 = 0; m_wn = 0; m_fb = 0; m_wm = 0;
      {m_bpol, m_early, m_fsl, m_msb} = '0;
      m_cnt = 0; m_lvl = 0; m_started = 0; m_fs = 0; m_sd = 0;
      m_slot = 0; m_w = 0; m_k = 0; m_word = '0;
    end else begin
      bit tick, push_ok, set_err;
      tick = m_bce && (m_cnt == m_div) && m_lvl;
      push_ok = s_valid && (mq.size() < 32);
      set_err = 0;
      if (!m_tx) begin
        m_started = 0; m_slot = 0; m_w = 0; m_k = 0; m_fs = 0; m_sd = 0;
      end else if (tick) begin
        if (m_early && !m_started) begin
          m_started = 1; m_fs = 1; m_sd = 0;
        end else begin
          int idx, width, nslot;
          bit endf;
          m_started = 1;
          if (m_k == 0) begin
            if (mq.size() > 0) m_word = mq.pop_front();
            else begin m_word = '0; set_err = 1; end
          end
          idx = m_msb ? m_fb - m_k : m_fb + m_k;
          m_sd = (idx >= 0 && idx <= 31) ? m_word[idx] : 1'b0;
          width = (m_w == 0) ? m_w0 + 1 : m_wn + 1;
          endf = (m_k == width - 1) && (m_w == m_fw);
          nslot = endf ? 0 : m_slot + 1;
          m_fs = m_early ? (nslot <= m_sw) : (m_slot <= m_sw);
          if (m_k == width - 1) begin
            m_k = 0;
            m_w = (m_w == m_fw) ? 0 : m_w + 1;
          end else m_k++;
          m_slot = nslot;
        end
      end
      if (push_ok) mq.push_back(s_data);
      if (!m_bce) begin m_cnt = 0; m_lvl = 0; end
      else if (m_cnt == m_div) begin m_cnt = 0; m_lvl = !m_lvl; end
      else m_cnt = (m_cnt + 1) % 256;
      if (set_err) m_err = 1;
      else if (cfg_we && cfg_addr == 0 && cfg_wdata[4]) m_err = 0;
      if (cfg_we) begin
        if (cfg_addr == 0) begin
          m_tx = cfg_wdata[0]; m_bce = cfg_wdata[1]; m_req = cfg_wdata[2]; m_ie = cfg_wdata[3];
        end else if (!m_tx) begin
          case (cfg_addr)
            3'd1: begin m_div = cfg_wdata[7:0]; m_bpol = cfg_wdata[8]; end
            3'd2: begin m_fw = cfg_wdata[4:0]; m_sw = cfg_wdata[12:8];
                        m_early = cfg_wdata[16]; m_fsl = cfg_wdata[17]; m_msb = cfg_wdata[18]; end
            3'd3: begin m_w0 = cfg_wdata[4:0]; m_wn = cfg_wdata[12:8]; m_fb = cfg_wdata[20:16]; end
            3'd4: m_wm = cfg_wdata[4:0];
            default: ;
          endcase
        end
      end
      live = 1;
    end
  end

  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      chk("R1 bclk", 32'(bclk_o), 32'(m_lvl ^ m_bpol));
      chk("R5 R9 fsync", 32'(fsync_o), 32'(m_fs ^ m_fsl));
      chk("R2 R4 R9 sdata", 32'(sdata_o), 32'(m_sd));
      chk("R3 ready", 32'(s_ready), 32'(mq.size() < 32));
      chk("R7 request", 32'(fifo_req_o), 32'(m_req && (mq.size() <= m_wm)));
      chk("R8 error flag", 32'(err_flag_o), 32'(m_err));
      chk("R8 irq", 32'(irq_o), 32'(m_err && m_ie));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  int seed = 1;
  task automatic feed(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!(s_valid && !s_ready)) begin
        s_valid = (i % every) == 0;
        seed = seed * 1103515245 + 12345;
        s_data = 32'(seed);
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state at the ports
    chk("R10 reset bclk", 32'(bclk_o), 0);
    chk("R10 reset fsync", 32'(fsync_o), 0);
    chk("R10 reset sdata", 32'(sdata_o), 0);
    chk("R10 reset req/irq", 32'({fifo_req_o, irq_o}), 0);
    chk("R10 reset ready", 32'(s_ready), 1);

    // A: msb-first 8-bit words, two per frame, plain sync
    wr(1, 32'h001);
    wr(2, 32'h0004_0301);
    wr(3, 32'h001F_0707);
    wr(4, 32'd4);
    feed(6, 1);
    wr(0, 32'hF);
    idle(200);
    // R6: locked write to the divider must leave the period at 4 cycles
    wr(1, 32'h005);
    begin
      int n;
      @(posedge bclk_o); @(negedge clk);
      n = 0;
      while (bclk_o) begin @(negedge clk); n++; end
      while (!bclk_o) begin @(negedge clk); n++; end
      chk("R6 locked divider period", 32'(n), 32'd4);
    end
    feed(700, 3);
    wr(0, 32'h1F);
    idle(100);
    wr(0, 32'h0);
    idle(10);
    wr(0, 32'h18);
    @(negedge clk);
    chk("R8 W1C clears irq", 32'(irq_o), 0);

    // B: lsb-first, early inverted sync, inverted bclk, unequal words, fill FIFO
    wr(0, 32'h0);
    wr(1, 32'h100);
    wr(2, 32'h0003_0002);
    wr(3, 32'h001C_030F);
    wr(4, 32'd31);
    wr(0, 32'h4);
    feed(40, 1);
    chk("R3 full stalls", 32'(s_ready), 0);
    wr(0, 32'hF);
    feed(1500, 2);
    wr(0, 32'h4);
    idle(20);

    // C: full-word sync, one word per frame, tx before bclk enable
    wr(0, 32'h0);
    wr(1, 32'h002);
    wr(2, 32'h0004_1F00);
    wr(3, 32'h0010_001F);
    wr(4, 32'd8);
    feed(10, 1);
    wr(0, 32'h1);
    idle(50);
    wr(0, 32'h7);
    feed(1200, 2);
    wr(0, 32'h0);
    idle(20);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule